// File: doc/BRIEF.md
# Endian-Selectable Byte-Addressed Word Memory

This block is a single-port storage array of 32-bit words that callers address in bytes. Every byte address names one byte. Each group of four consecutive byte addresses that starts at a multiple of four forms one stored word. A request carries a byte address, an access width (byte, halfword or word), a write flag and write data. A loaded value is returned right-justified and zero-extended on the 32-bit read bus.

The `big_endian` configuration input is sampled with each request and picks the lane order. In big-endian order the lowest byte address inside a word maps to the most significant byte. In little-endian order it maps to the least significant byte. Every request is checked for natural alignment. A request whose address is not a multiple of its width in bytes is not performed. The block reports it on an error output instead.

Top module: `byte_mem_endian`

## Requirements
- R1: With `big_endian` low, the byte at address A sits in bits [8k+7:8k] of the word at A with its low two bits cleared, where k = A mod 4.
- R2: With `big_endian` high, the byte at address A sits in bits [8(3-k)+7:8(3-k)] of that word, where k = A mod 4.
- R3: A little-endian halfword load at even address A returns byte A in bits [7:0] and byte A+1 in bits [15:8].
- R4: A big-endian halfword load at even address A returns byte A in bits [15:8] and byte A+1 in bits [7:0].
- R5: Byte and halfword loads return zeros in every read-bus bit above the loaded value.
- R6: A store writes only the bytes it addresses. A byte store takes `wdata[7:0]` and a halfword store takes `wdata[15:0]`. All other bytes of the word keep their contents.
- R7: `size` encodes 0 = byte, 1 = halfword, 2 = word, 3 = reserved. An access is aligned when its address is a multiple of 1, 2 or 4 bytes respectively; the reserved code is never aligned. `misalign` is high in the cycle after a non-aligned request and low after any other cycle.
- R8: A non-aligned store changes no byte of the memory.
- R9: A non-aligned load returns zero on `rdata`.
- R10: `rdata` is registered and shows a load's value one clock after the request. It holds its value through idle cycles and stores. A load leaves the memory unchanged.
- R11: While `rst_n` is low, `rdata` and `misalign` are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| req | input | 1 | Access request in this cycle |
| big_endian | input | 1 | Lane order: 1 = big-endian, 0 = little-endian |
| addr | input | ADDR_W | Byte address |
| size | input | 2 | Access width code (0 byte, 1 halfword, 2 word, 3 reserved) |
| wr_en | input | 1 | 1 = store, 0 = load |
| wdata | input | 32 | Store data, right-justified |
| rdata | output | 32 | Registered load data, zero-extended |
| misalign | output | 1 | One-cycle alignment error flag |

## Verification
On every cycle, the bound checker tracks the alignment rule: the flag must follow each bad request and must clear after any other cycle. It also checks that a refused load reads as zero, that narrow loads carry zero upper bits, and that the read register holds when no load is issued. Lane placement cannot be seen from one cycle of port activity. Only the bench's store-then-load scenarios can show it: big-endian versus little-endian byte and halfword order, partial stores that leave neighbouring bytes intact, and refused stores that leave memory untouched. Reset values are also checked by the bench alone.

// File: rtl/bam_pkg.sv
package bam_pkg;
  localparam int unsigned LANES  = 4;
  localparam int unsigned LANE_W = 8;
  localparam int unsigned WORD_W = LANES * LANE_W;

  typedef enum logic [1:0] {
    ACC_BYTE = 2'b00,
    ACC_HALF = 2'b01,
    ACC_WORD = 2'b10,
    ACC_RSVD = 2'b11
  } acc_size_e;
endpackage

// File: rtl/bam_rst_sync.sv
module bam_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= 2'b00;
    else           sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_out = sync_q[1];
endmodule

// File: rtl/bam_lane_map.sv
// Decides alignment, the lowest lane touched and the per-lane write mask.
module bam_lane_map
  import bam_pkg::*;
(
  input  logic             big_endian,
  input  acc_size_e        size,
  input  logic [1:0]       offset,
  output logic             aligned,
  output logic [1:0]       low_lane,
  output logic [LANES-1:0] lane_en
);
  logic [1:0]       span_m1;
  logic [LANES-1:0] mask;

  always_comb begin
    unique case (size)
      ACC_BYTE: begin aligned = 1'b1;            span_m1 = 2'd0; mask = 4'b0001; end
      ACC_HALF: begin aligned = ~offset[0];      span_m1 = 2'd1; mask = 4'b0011; end
      ACC_WORD: begin aligned = (offset == 2'd0); span_m1 = 2'd3; mask = 4'b1111; end
      default:  begin aligned = 1'b0;            span_m1 = 2'd0; mask = 4'b0000; end
    endcase
    // big-endian: lane = 4 - bytes - offset, computed modulo 4
    low_lane = big_endian ? (~offset - span_m1) : offset;
    lane_en  = aligned ? (mask << low_lane) : '0;
  end
endmodule

// File: rtl/bam_word_store.sv
// One byte-wide array per lane so each lane has its own write enable.
module bam_word_store
  import bam_pkg::*;
#(
  parameter int unsigned IDX_W = 6,
  localparam int unsigned WORDS = 1 << IDX_W
) (
  input  logic              clk,
  input  logic [IDX_W-1:0]  idx,
  input  logic [LANES-1:0]  wr_lane,
  input  logic [WORD_W-1:0] wr_word,
  output logic [WORD_W-1:0] rd_word
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] cells [WORDS];

    always_ff @(posedge clk) begin
      if (wr_lane[g]) cells[idx] <= wr_word[g*LANE_W +: LANE_W];
    end

    assign rd_word[g*LANE_W +: LANE_W] = cells[idx];
  end
endmodule

// File: rtl/bam_load_fmt.sv
// Right-justifies and zero-extends the addressed bytes of a word.
module bam_load_fmt
  import bam_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  input  logic [1:0]        low_lane,
  input  acc_size_e         size,
  input  logic              aligned,
  output logic [WORD_W-1:0] value
);
  logic [WORD_W-1:0] shifted;

  always_comb begin
    shifted = word >> {low_lane, 3'b000};
    if (!aligned) begin
      value = '0;
    end else begin
      unique case (size)
        ACC_BYTE: value = {{(WORD_W-LANE_W){1'b0}}, shifted[LANE_W-1:0]};
        ACC_HALF: value = {{(WORD_W-2*LANE_W){1'b0}}, shifted[2*LANE_W-1:0]};
        default:  value = shifted;
      endcase
    end
  end
endmodule

// File: rtl/byte_mem_endian.sv
module byte_mem_endian
  import bam_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  localparam int unsigned IDX_W = ADDR_W - 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              big_endian,
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        size,
  input  logic              wr_en,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output logic              misalign
);
  acc_size_e         acc_size;
  logic              rst_n_s;
  logic              aligned;
  logic [1:0]        low_lane;
  logic [LANES-1:0]  lane_en;
  logic [LANES-1:0]  wr_lane;
  logic [WORD_W-1:0] wr_word;
  logic [WORD_W-1:0] rd_word;
  logic [WORD_W-1:0] load_val;
  logic              rd_ce;
  logic [WORD_W-1:0] rdata_d, rdata_q;
  logic              mis_d, mis_q;

  assign acc_size = acc_size_e'(size);

  bam_rst_sync u_rst (.clk(clk), .rst_n_in(rst_n), .rst_n_out(rst_n_s));

  bam_lane_map u_map (
    .big_endian(big_endian), .size(acc_size), .offset(addr[1:0]),
    .aligned(aligned), .low_lane(low_lane), .lane_en(lane_en)
  );

  assign wr_lane = (req && wr_en) ? lane_en : '0;
  assign wr_word = wdata << {low_lane, 3'b000};

  bam_word_store #(.IDX_W(IDX_W)) u_store (
    .clk(clk), .idx(addr[ADDR_W-1:2]), .wr_lane(wr_lane),
    .wr_word(wr_word), .rd_word(rd_word)
  );

  bam_load_fmt u_fmt (
    .word(rd_word), .low_lane(low_lane), .size(acc_size),
    .aligned(aligned), .value(load_val)
  );

  // next state
  always_comb begin
    rd_ce   = req && !wr_en;
    rdata_d = load_val;
    mis_d   = req && !aligned;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      rdata_q <= '0;
      mis_q   <= 1'b0;
    end else begin
      if (rd_ce) rdata_q <= rdata_d;
      mis_q <= mis_d;
    end
  end

  assign rdata    = rdata_q;
  assign misalign = mis_q;
endmodule

// File: rtl/bam_chk.sv
module bam_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req,
  input logic        wr_en,
  input logic [1:0]  size,
  input logic [1:0]  addr_lo,
  input logic [31:0] rdata,
  input logic        misalign
);
  logic bad;
  assign bad = (size == 2'b11) || (size == 2'b01 && addr_lo[0]) ||
               (size == 2'b10 && addr_lo != 2'b00);

  // R7
  misalign_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req && bad) |=> misalign);

  // R7
  misalign_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!req || !bad) |=> !misalign);

  // R9
  misload_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !wr_en && bad) |=> (rdata == 32'h0));

  // R5
  byte_zext_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !wr_en && size == 2'b00) |=> (rdata[31:8] == 24'h0));

  // R5
  half_zext_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !wr_en && size == 2'b01) |=> (rdata[31:16] == 16'h0));

  // R10
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(req && !wr_en) |=> $stable(rdata));
endmodule

bind byte_mem_endian bam_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req(req), .wr_en(wr_en), .size(size),
  .addr_lo(addr[1:0]), .rdata(rdata), .misalign(misalign)
);

// File: tb/byte_mem_endian_test.sv
`timescale 1ns/1ps
module byte_mem_endian_test;
  typedef struct packed {
    logic        be;
    logic        we;
    logic [1:0]  sz;
    logic [7:0]  ad;
    logic [31:0] wd;
    logic [31:0] ex;
    logic        mis;
    logic [3:0]  rq;
  } vec_t;

  localparam int NV = 28;
  localparam vec_t VECS [NV] = '{
    '{1'b0,1'b1,2'd2,8'h00,32'h11223344,32'h0,1'b0,4'd6},  // R6 word store
    '{1'b0,1'b0,2'd2,8'h00,32'h0,32'h11223344,1'b0,4'd10}, // R10
    '{1'b0,1'b0,2'd0,8'h00,32'h0,32'h00000044,1'b0,4'd1},  // R1
    '{1'b0,1'b0,2'd0,8'h03,32'h0,32'h00000011,1'b0,4'd1},  // R1
    '{1'b1,1'b0,2'd0,8'h00,32'h0,32'h00000011,1'b0,4'd2},  // R2
    '{1'b1,1'b0,2'd0,8'h02,32'h0,32'h00000033,1'b0,4'd2},  // R2
    '{1'b0,1'b0,2'd1,8'h02,32'h0,32'h00001122,1'b0,4'd3},  // R3
    '{1'b0,1'b0,2'd1,8'h00,32'h0,32'h00003344,1'b0,4'd3},  // R3
    '{1'b1,1'b0,2'd1,8'h02,32'h0,32'h00003344,1'b0,4'd4},  // R4
    '{1'b1,1'b0,2'd1,8'h00,32'h0,32'h00001122,1'b0,4'd4},  // R4
    '{1'b1,1'b1,2'd0,8'h01,32'h000000AA,32'h0,1'b0,4'd6},  // R6 BE byte store
    '{1'b0,1'b0,2'd2,8'h00,32'h0,32'h11AA3344,1'b0,4'd6},  // R6
    '{1'b0,1'b1,2'd2,8'h04,32'h55667788,32'h0,1'b0,4'd6},  // R6
    '{1'b0,1'b1,2'd1,8'h06,32'h0000BEEF,32'h0,1'b0,4'd6},  // R6 half store
    '{1'b1,1'b0,2'd2,8'h04,32'h0,32'hBEEF7788,1'b0,4'd6},  // R6
    '{1'b0,1'b0,2'd1,8'h06,32'h0,32'h0000BEEF,1'b0,4'd5},  // R5
    '{1'b1,1'b0,2'd0,8'h04,32'h0,32'h000000BE,1'b0,4'd5},  // R5
    '{1'b0,1'b1,2'd0,8'h05,32'hFFFFFF12,32'h0,1'b0,4'd6},  // R6 upper wdata ignored
    '{1'b0,1'b0,2'd2,8'h04,32'h0,32'hBEEF1288,1'b0,4'd6},  // R6
    '{1'b0,1'b0,2'd1,8'h01,32'h0,32'h0,1'b1,4'd9},         // R9
    '{1'b1,1'b0,2'd2,8'h02,32'h0,32'h0,1'b1,4'd7},         // R7
    '{1'b0,1'b1,2'd2,8'h05,32'h0,32'h0,1'b1,4'd8},         // R8 refused store
    '{1'b0,1'b0,2'd2,8'h04,32'h0,32'hBEEF1288,1'b0,4'd8},  // R8
    '{1'b1,1'b1,2'd1,8'h03,32'hFFFF,32'h0,1'b1,4'd8},      // R8 refused store
    '{1'b1,1'b0,2'd2,8'h00,32'h0,32'h11AA3344,1'b0,4'd8},  // R8
    '{1'b0,1'b0,2'd3,8'h00,32'h0,32'h0,1'b1,4'd7},         // R7 reserved width
    '{1'b0,1'b0,2'd0,8'h07,32'h0,32'h000000BE,1'b0,4'd7},  // R7 odd byte is fine
    '{1'b1,1'b0,2'd1,8'h04,32'h0,32'h0000BEEF,1'b0,4'd4}   // R4
  };

  logic        clk, rst_n, req, big_endian, wr_en, misalign;
  logic [7:0]  addr;
  logic [1:0]  size;
  logic [31:0] wdata, rdata;
  int checks, fails;
  bit done;

  byte_mem_endian uut (
    .clk(clk), .rst_n(rst_n), .req(req), .big_endian(big_endian),
    .addr(addr), .size(size), .wr_en(wr_en), .wdata(wdata),
    .rdata(rdata), .misalign(misalign)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic access(input logic be, input logic we, input logic [1:0] sz,
                        input logic [7:0] ad, input logic [31:0] wd);
    req = 1'b1; big_endian = be; wr_en = we; size = sz; addr = ad; wdata = wd;
    @(negedge clk);
    req = 1'b0;
  endtask

  task automatic idle();
    req = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    checks = 0; fails = 0; done = 1'b0;
    req = 1'b0; big_endian = 1'b0; wr_en = 1'b0; size = 2'd0; addr = '0; wdata = '0;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check("R11 rdata in reset", rdata, 32'h0);
    check("R11 misalign in reset", {31'h0, misalign}, 32'h0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      access(VECS[i].be, VECS[i].we, VECS[i].sz, VECS[i].ad, VECS[i].wd);
      check($sformatf("R%0d vec %0d misalign", VECS[i].rq, i), {31'h0, misalign}, {31'h0, VECS[i].mis});
      if (!VECS[i].we)
        check($sformatf("R%0d vec %0d rdata", VECS[i].rq, i), rdata, VECS[i].ex);
    end

    // R7: flag lasts one cycle
    access(1'b0, 1'b0, 2'd2, 8'h01, 32'h0);
    check("R7 flag raised", {31'h0, misalign}, 32'h1);
    idle();
    check("R7 flag cleared", {31'h0, misalign}, 32'h0);

    // R10: hold through idle and stores, loads leave memory unchanged
    access(1'b0, 1'b0, 2'd2, 8'h00, 32'h0);
    check("R10 load", rdata, 32'h11AA3344);
    idle();
    check("R10 hold idle", rdata, 32'h11AA3344);
    access(1'b0, 1'b1, 2'd2, 8'h08, 32'hDEADBEEF);
    check("R10 hold on store", rdata, 32'h11AA3344);
    access(1'b0, 1'b0, 2'd2, 8'h00, 32'h0);
    check("R10 reload unchanged", rdata, 32'h11AA3344);
    access(1'b1, 1'b0, 2'd2, 8'h08, 32'h0);
    check("R10 stored word", rdata, 32'hDEADBEEF);

    // R11: asynchronous reset mid-run
    access(1'b0, 1'b0, 2'd3, 8'h00, 32'h0);
    #2 rst_n = 1'b0;
    #1;
    check("R11 misalign cleared by reset", {31'h0, misalign}, 32'h0);
    access(1'b0, 1'b0, 2'd2, 8'h08, 32'h0);
    idle();
    check("R11 rdata cleared by reset", rdata, 32'h0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    access(1'b1, 1'b0, 2'd0, 8'h08, 32'h0);
    check("R2 after reset", rdata, 32'h000000DE);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule